// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM with Aligned Write Data

This block is a single-clock synchronous SRAM. Every address, control and data input is captured on the rising clock edge. Reads and writes use the same two-stage pipeline. A read returns its data two enabled cycles after its address cycle. A write takes its data two enabled cycles after its address cycle. Because both follow the same timing, the bus can switch between reads and writes on every cycle without idle slots.

A command cycle loads an external address and picks the operation. Continuation cycles then step an internal 2-bit beat counter through a four-word burst. A mode input, sampled when the burst is loaded, selects the burst order: interleaved (XOR) or linear (wrapping add). Three chip selects qualify each load. Byte-lane enables mask each written word. A clock enable freezes the whole pipeline, including the read outputs. A read whose address matches a write still in flight returns that write's data, merged per byte lane.

Top module: `zt_sram`

## Requirements
- R1: A read issued on an enabled rising edge drives `rvalid` high, with the word on `rdata`, after the second enabled rising edge that follows. `rvalid` is low after any enabled edge that does not complete a read.
- R2: A write takes `wdata` on the second enabled rising edge after its address cycle. Only the lanes whose `bw_n` bit is low (bit i covers `wdata[8i+7:8i]`) are stored. `bw_n` is sampled in the address cycle.
- R3: With `adv` low, a new address and operation are loaded. `we_n` low means write, and high means read. With `adv` high, the beat counter advances, and the operation and selection of the loading cycle are kept; `we_n` is then ignored.
- R4: In linear order (`order_il` low at load), the low two address bits of beat n are the start bits plus n, modulo 4. The upper address bits stay fixed for the whole burst.
- R5: In interleaved order (`order_il` high at load), the low two address bits of beat n are the start bits XOR n. `order_il` is only sampled in load cycles.
- R6: A load is selected only when `sel_hi_a` and `sel_hi_b` are high and `sel_lo_n` is low. Otherwise the load is a deselect: it writes nothing and gives no `rvalid`. Its continuations stay deselected.
- R7: While `cke_n` is high, all inputs are ignored and every internal and output register keeps its value.
- R8: Reads and writes may alternate on consecutive cycles. A read always returns the latest data written to its address, including byte lanes of a write that is still pending.
- R9: While reset is low and after its release, `rvalid` and `rdata` are 0. Until the first load, continuation cycles are deselects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Clock enable, low = active |
| sel_hi_a | input | 1 | Chip select, active high |
| sel_hi_b | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| adv | input | 1 | High = advance burst, low = load address |
| we_n | input | 1 | Low = write on a load cycle |
| bw_n | input | NBYTES | Active-low byte-lane write enables |
| order_il | input | 1 | Burst order: 1 interleaved, 0 linear |
| addr | input | ADDR_W | Word address |
| wdata | input | NBYTES*BYTE_W | Write data, two enabled cycles after address |
| rdata | output | NBYTES*BYTE_W | Read data |
| rvalid | output | 1 | Read data valid |

## Verification
A wrong beat counter or latched burst order sends a burst to the wrong word. This shows on `rdata` two enabled cycles after the bad beat, or at the first later read of that word. A lost write bypass returns stale lanes on a read issued right after a write to the same word, so the error is visible in the very next read slot. A pipeline register that ignores the clock enable shifts `rvalid` by the length of the suspend, so it shows at the first valid that should have been held.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low address bits of a burst beat: XOR walk or wrapping increment
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] beat,
                                         input logic       il);
    return il ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/zt_sram_burst.sv
module zt_sram_burst
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              adv,
  input  logic              we_n,
  input  logic              sel,
  input  logic              mode_il,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBYTES-1:0] bw_n,
  output op_e               cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [NBYTES-1:0] cmd_be
);

  localparam int HI = ADDR_W - 1;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        beat_q, beat_d;
  op_e               op_q, op_d;
  logic              il_q, il_d;

  always_comb begin
    base_d = base_q;
    beat_d = beat_q + 2'd1;
    op_d   = op_q;
    il_d   = il_q;
    if (!adv) begin
      base_d = addr;
      beat_d = 2'd0;
      il_d   = mode_il;
      if (!sel)       op_d = OP_IDLE;
      else if (!we_n) op_d = OP_WRITE;
      else            op_d = OP_READ;
    end
  end

  always_comb begin
    if (!adv) cmd_addr = addr;
    else      cmd_addr = {base_q[HI:2], beat_lo(base_q[1:0], beat_d, il_q)};
    cmd_op = op_d;
    cmd_be = ~bw_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      op_q   <= OP_IDLE;
      il_q   <= 1'b0;
    end else if (en) begin
      base_q <= base_d;
      beat_q <= beat_d;
      op_q   <= op_d;
      il_q   <= il_d;
    end
  end

  AST_BURST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv) |=> (!(en && adv) || cmd_addr[HI:2] == $past(cmd_addr[HI:2]))); // R4

  AST_CONT_KEEPS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv) |=> (!(en && adv) || cmd_op == $past(cmd_op))); // R3

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !sel) |-> cmd_op == OP_IDLE); // R6

endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [NBYTES-1:0]        wr_be,
  input  logic [NBYTES*BYTE_W-1:0] wr_data,
  output logic [NBYTES*BYTE_W-1:0] rd_data
);

  localparam int DATA_W = NBYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_mrg;
  logic [DATA_W-1:0] rd_q;
  logic              same_addr;

  assign same_addr = wr_en && (wr_addr == rd_addr);

  // Per-lane bypass of the write that commits on the same edge
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign rd_mrg[g*BYTE_W +: BYTE_W] = (same_addr && wr_be[g])
                                        ? wr_data[g*BYTE_W +: BYTE_W]
                                        : mem[rd_addr][g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (en && wr_en) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (wr_be[b]) mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            rd_q <= '0;
    else if (en && rd_en)  rd_q <= rd_mrg;
  end

  assign rd_data = rd_q;

  AST_RDQ_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && rd_en) |=> $stable(rd_data)); // R7

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cke_n,
  input  logic                     sel_hi_a,
  input  logic                     sel_hi_b,
  input  logic                     sel_lo_n,
  input  logic                     adv,
  input  logic                     we_n,
  input  logic [NBYTES-1:0]        bw_n,
  input  logic                     order_il,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  output logic [NBYTES*BYTE_W-1:0] rdata,
  output logic                     rvalid
);

  localparam int DATA_W = NBYTES * BYTE_W;

  logic              en;
  logic              sel;
  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [NBYTES-1:0] cmd_be;

  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [NBYTES-1:0] s1_be, s2_be;

  logic [DATA_W-1:0] arr_rd;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q, rvalid_d;

  assign en  = ~cke_n;
  assign sel = sel_hi_a & sel_hi_b & ~sel_lo_n;

  zt_sram_burst #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .adv      (adv),
    .we_n     (we_n),
    .sel      (sel),
    .mode_il  (order_il),
    .addr     (addr),
    .bw_n     (bw_n),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr),
    .cmd_be   (cmd_be)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_be   <= '0;
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
      s2_be   <= '0;
    end else if (en) begin
      s1_op   <= cmd_op;
      s1_addr <= cmd_addr;
      s1_be   <= cmd_be;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  zt_sram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .rd_en   (s1_op == OP_READ),
    .rd_addr (s1_addr),
    .wr_en   (s2_op == OP_WRITE),
    .wr_addr (s2_addr),
    .wr_be   (s2_be),
    .wr_data (wdata),
    .rd_data (arr_rd)
  );

  always_comb begin
    rvalid_d = (s2_op == OP_READ);
    rdata_d  = rvalid_d ? arr_rd : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (en) begin
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;

  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(rvalid) && $stable(rdata))); // R7

  AST_VALID_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> $past(en)); // R1

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (en && s1_op != OP_READ) |=> ##1 (!$past(en) || !rvalid)); // R6

endmodule

// File: tb/zt_sram_test.sv
module zt_sram_test;

  localparam int ADDR_W = 6;
  localparam int NBYTES = 2;
  localparam int BYTE_W = 8;
  localparam int DATA_W = NBYTES * BYTE_W;
  localparam int NVEC   = 18;

  typedef struct packed {
    logic              adv;
    logic              wr;
    logic              cs;
    logic              il;
    logic [ADDR_W-1:0] a;
    logic [NBYTES-1:0] be;
    logic [DATA_W-1:0] wd;
    logic              chk;
    logic [DATA_W-1:0] ed;
  } vec_t;

  // adv, wr, cs, il, addr, be, wdata, expect-valid, expect-data
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b1, 1'b1, 1'b0, 6'h05, 2'b11, 16'hA000, 1'b0, 16'h0000}, // R4 linear write burst
    '{1'b1, 1'b1, 1'b1, 1'b0, 6'h00, 2'b11, 16'hA001, 1'b0, 16'h0000},
    '{1'b1, 1'b1, 1'b1, 1'b0, 6'h00, 2'b11, 16'hA002, 1'b0, 16'h0000},
    '{1'b1, 1'b1, 1'b1, 1'b0, 6'h00, 2'b11, 16'hA003, 1'b0, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 1'b1, 6'h06, 2'b11, 16'h0000, 1'b1, 16'hA001}, // R5 interleaved read
    '{1'b1, 1'b1, 1'b1, 1'b0, 6'h00, 2'b11, 16'h0000, 1'b1, 16'hA002}, // R3 we_n ignored
    '{1'b1, 1'b0, 1'b1, 1'b0, 6'h00, 2'b11, 16'h0000, 1'b1, 16'hA003},
    '{1'b1, 1'b0, 1'b1, 1'b0, 6'h00, 2'b11, 16'h0000, 1'b1, 16'hA000},
    '{1'b0, 1'b1, 1'b1, 1'b0, 6'h10, 2'b11, 16'h1234, 1'b0, 16'h0000}, // R8 write then read
    '{1'b0, 1'b0, 1'b1, 1'b0, 6'h10, 2'b11, 16'h0000, 1'b1, 16'h1234},
    '{1'b0, 1'b1, 1'b1, 1'b0, 6'h10, 2'b01, 16'hFF56, 1'b0, 16'h0000}, // R2 lane 0 only
    '{1'b0, 1'b0, 1'b1, 1'b0, 6'h10, 2'b11, 16'h0000, 1'b1, 16'h1256},
    '{1'b0, 1'b1, 1'b0, 1'b0, 6'h06, 2'b11, 16'h0000, 1'b0, 16'h0000}, // R6 deselect write
    '{1'b1, 1'b1, 1'b1, 1'b0, 6'h00, 2'b11, 16'h0000, 1'b0, 16'h0000}, // R6 continuation
    '{1'b0, 1'b0, 1'b1, 1'b0, 6'h06, 2'b11, 16'h0000, 1'b1, 16'hA001},
    '{1'b0, 1'b1, 1'b1, 1'b0, 6'h20, 2'b11, 16'hBEEF, 1'b0, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 1'b0, 6'h07, 2'b11, 16'h0000, 1'b1, 16'hA002},
    '{1'b0, 1'b0, 1'b1, 1'b0, 6'h20, 2'b11, 16'h0000, 1'b1, 16'hBEEF}
  };

  logic              clk;
  logic              rst_n;
  logic              cke_n;
  logic              sel_hi_a, sel_hi_b, sel_lo_n;
  logic              adv, we_n, order_il;
  logic [NBYTES-1:0] bw_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              rvalid;

  int checks;
  int errors;
  bit done;

  zt_sram #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) uut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n),
    .sel_hi_a(sel_hi_a), .sel_hi_b(sel_hi_b), .sel_lo_n(sel_lo_n),
    .adv(adv), .we_n(we_n), .bw_n(bw_n), .order_il(order_il),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic a, input logic wr, input logic cs,
                       input logic il, input logic [ADDR_W-1:0] ad,
                       input logic [NBYTES-1:0] be);
    adv      = a;
    we_n     = ~wr;
    sel_hi_a = 1'b1;
    sel_hi_b = 1'b1;
    sel_lo_n = ~cs;
    order_il = il;
    addr     = ad;
    bw_n     = ~be;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    rst_n  = 1'b0;
    cke_n  = 1'b0;
    wdata  = '0;
    drive(1'b1, 1'b0, 1'b1, 1'b0, '0, 2'b11);
    tick();
    check("R9 rvalid in reset", {15'd0, rvalid}, 16'd0);
    check("R9 rdata in reset", rdata, 16'd0);
    tick();
    @(negedge clk);
    rst_n = 1'b1;
    // continuation cycles before any load must stay deselected (R9)
    for (int k = 0; k < 4; k++) tick();
    check("R9 no valid before first load", {15'd0, rvalid}, 16'd0);
    check("R9 rdata stays zero", rdata, 16'd0);

    // vector table walk (R1..R8)
    for (int i = 0; i < NVEC + 2; i++) begin
      @(negedge clk);
      if (i < NVEC) drive(VEC[i].adv, VEC[i].wr, VEC[i].cs, VEC[i].il, VEC[i].a, VEC[i].be);
      else          drive(1'b0, 1'b0, 1'b0, 1'b0, '0, 2'b11);
      if (i >= 2) wdata = VEC[i-2].wd;
      tick();
      if (i >= 2) begin
        check($sformatf("R1 valid row %0d", i - 2), {15'd0, rvalid}, {15'd0, VEC[i-2].chk});
        if (VEC[i-2].chk)
          check($sformatf("R8 data row %0d", i - 2), rdata, VEC[i-2].ed);
      end
    end

    // clock suspend: read 0x07 with three frozen cycles in between (R7)
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 6'h07, 2'b11);
    tick();
    @(negedge clk);
    cke_n = 1'b1;
    drive(1'b0, 1'b1, 1'b1, 1'b0, 6'h07, 2'b11);
    wdata = 16'h0000;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R7 frozen pipeline no valid", {15'd0, rvalid}, 16'd0);
    end
    @(negedge clk);
    cke_n = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 1'b0, '0, 2'b11);
    tick();
    check("R1 one enabled edge not enough", {15'd0, rvalid}, 16'd0);
    tick();
    check("R1 valid after two enabled edges", {15'd0, rvalid}, 16'd1);
    check("R7 read data across suspend", rdata, 16'hA002);
    @(negedge clk);
    cke_n = 1'b1;
    tick();
    check("R7 valid held while suspended", {15'd0, rvalid}, 16'd1);
    check("R7 data held while suspended", rdata, 16'hA002);
    @(negedge clk);
    cke_n = 1'b0;
    tick();
    check("R1 valid drops after idle edge", {15'd0, rvalid}, 16'd0);

    // the write presented during suspend must not have landed (R7)
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b1, 1'b0, 6'h07, 2'b11);
    tick();
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, '0, 2'b11);
    tick();
    tick();
    check("R7 suspended write ignored", rdata, 16'hA002);

    finish_run();
  end

endmodule